// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode. Fetch hands it a stream of instruction bytes, always in big-endian instruction order no matter which data endianness the core uses. The block collects the bytes and hands decode one whole instruction per cycle, left-aligned, with a code giving its length.

The length of each instruction comes from its first halfword alone. Let the first byte be `b0` and the second `b1`. If the 6-bit major field `b0[7:2]` is non-zero, the instruction is a plain 32-bit one. If the major field is zero, a 3-bit length selector `{b0[1:0], b1[7]}` picks one of four escape classes: a 16-bit compressed form, a 48-bit form, a 64-bit form, or a variable-length block form. The variable-length block form is not measured here. The block flags it as unsupported and steps over its first halfword. A flush drops everything buffered, and the next byte delivered starts a new instruction.

Fetch delivers `IN_BYTES` bytes (one or two) per accepted beat, with the first byte in the most significant lane. The buffer holds eight bytes, which is the longest instruction.

Top module: `ia_aligner`

## Requirements
- R1: `out_insn[63:56]` carries the first byte of the instruction and later bytes follow in descending lanes. Every lane beyond the instruction's length reads zero.
- R2: When the major field `b0[7:2]` is non-zero, the block emits 4 bytes with `out_len` = 1 and `out_unsup` = 0.
- R3: When the major field is zero and the selector `{b0[1:0],b1[7]}` is 000 or 001, the block emits 2 bytes with `out_len` = 0 and `out_unsup` = 0.
- R4: When the major field is zero and the selector is 010 or 011, the block emits 6 bytes with `out_len` = 2.
- R5: When the major field is zero and the selector is 100 or 101, the block emits 8 bytes with `out_len` = 3.
- R6: When the major field is zero and the selector is 110 or 111, the block raises `out_unsup`, reports `out_len` = 0, and consumes exactly 2 bytes.
- R7: `out_valid` stays low until every byte of the instruction at the head of the buffer has arrived. Emitted instructions follow stream order with no gaps.
- R8: A cycle with `flush` high shows `out_valid` low and empties the buffer. Bytes that were buffered before the flush are never emitted.
- R9: `in_ready` falls whenever fewer than `IN_BYTES` buffer slots are free, so the buffer never holds more than 8 bytes. A beat is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R10: Out of reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop buffered bytes and realign |
| in_valid | input | 1 | Fetch beat present |
| in_data | input | IN_BYTES*8 | Fetch bytes, first byte in the top lane |
| in_ready | output | 1 | Buffer can take a beat this cycle |
| out_valid | output | 1 | A whole instruction is presented |
| out_insn | output | 64 | Instruction bytes, left-aligned, zero-filled |
| out_len | output | 2 | 0: 16-bit, 1: 32-bit, 2: 48-bit, 3: 64-bit |
| out_unsup | output | 1 | Variable-length block form seen |

## Verification
The assertions assume that the fetch stream is made of whole instructions and that nothing drives `flush` and `in_valid` in the same cycle. They also assume that decode takes every instruction presented, because the output has no back-pressure. The bench builds each stream from complete encodings and keeps `in_valid` low while `flush` is pulsed. It offers each beat only when the cycle that takes it will see `in_ready` high.

// File: rtl/ia_aligner_pkg.sv
package ia_aligner_pkg;

    localparam int MAX_INSN_BYTES = 8;

    typedef enum logic [1:0] {
        LEN_16 = 2'd0,
        LEN_32 = 2'd1,
        LEN_48 = 2'd2,
        LEN_64 = 2'd3
    } len_code_e;

    typedef struct packed {
        len_code_e  code;
        logic       unsup;
        logic [3:0] nbytes;
    } len_info_t;

    function automatic len_info_t classify(input logic [7:0] b0, input logic [7:0] b1);
        len_info_t r;
        logic [2:0] sel;
        sel = {b0[1:0], b1[7]};
        r.unsup = 1'b0;
        if (b0[7:2] != 6'd0) begin
            r.code   = LEN_32;
            r.nbytes = 4'd4;
        end else begin
            unique case (sel[2:1])
                2'b00: begin r.code = LEN_16; r.nbytes = 4'd2; end
                2'b01: begin r.code = LEN_48; r.nbytes = 4'd6; end
                2'b10: begin r.code = LEN_64; r.nbytes = 4'd8; end
                default: begin
                    r.code   = LEN_16;
                    r.nbytes = 4'd2;
                    r.unsup  = 1'b1;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ia_len_decode.sv
module ia_len_decode
    import ia_aligner_pkg::*;
(
    input  logic [15:0] head_hw,
    output len_info_t   info
);
    always_comb begin
        info = classify(head_hw[15:8], head_hw[7:0]);
    end
endmodule

// File: rtl/ia_byte_queue.sv
module ia_byte_queue #(
    parameter int DEPTH    = 8,
    parameter int IN_BYTES = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     push,
    input  logic [IN_BYTES*8-1:0]    push_data,
    input  logic [CNT_W-1:0]         pop_n,
    output logic [DEPTH-1:0][7:0]    q_bytes,
    output logic [CNT_W-1:0]         q_count
);
    logic [DEPTH-1:0][7:0] nxt_bytes;
    logic [CNT_W-1:0]      kept;
    logic [CNT_W-1:0]      nxt_count;

    always_comb begin
        kept = q_count - pop_n;
        for (int i = 0; i < DEPTH; i++) begin
            nxt_bytes[i] = 8'h00;
            for (int j = 0; j < DEPTH; j++) begin
                if ((j == i + int'(pop_n)) && (j < int'(q_count)))
                    nxt_bytes[i] = q_bytes[j];
            end
            for (int k = 0; k < IN_BYTES; k++) begin
                if (push && (i == int'(kept) + k))
                    nxt_bytes[i] = push_data[(IN_BYTES-1-k)*8 +: 8];
            end
        end
        nxt_count = kept + (push ? CNT_W'(IN_BYTES) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q_bytes <= '0;
            q_count <= '0;
        end else begin
            q_bytes <= nxt_bytes;
            q_count <= nxt_count;
        end
    end
endmodule

// File: rtl/ia_aligner.sv
module ia_aligner
    import ia_aligner_pkg::*;
#(
    parameter int IN_BYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  in_valid,
    input  logic [IN_BYTES*8-1:0] in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [63:0]           out_insn,
    output logic [1:0]            out_len,
    output logic                  out_unsup
);
    localparam int DEPTH = MAX_INSN_BYTES;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][7:0] q_bytes;
    logic [CNT_W-1:0]      q_count;
    logic [CNT_W-1:0]      pop_n;
    len_info_t             info;
    logic                  whole;
    logic                  push;

    ia_len_decode u_dec (
        .head_hw (MAX_INSN_BYTES >= 2 ? {q_bytes[0], q_bytes[1]} : 16'h0),
        .info    (info)
    );

    assign whole     = (q_count >= CNT_W'(2)) && (q_count >= CNT_W'(info.nbytes));
    assign out_valid = whole && !flush;
    assign pop_n     = out_valid ? CNT_W'(info.nbytes) : CNT_W'(0);
    assign in_ready  = q_count <= CNT_W'(DEPTH - IN_BYTES);
    assign push      = in_valid && in_ready && !flush;
    assign out_len   = info.code;
    assign out_unsup = out_valid && info.unsup;

    always_comb begin
        for (int k = 0; k < MAX_INSN_BYTES; k++) begin
            out_insn[63-8*k -: 8] = (k < int'(info.nbytes)) ? q_bytes[k] : 8'h00;
        end
    end

    ia_byte_queue #(.DEPTH(DEPTH), .IN_BYTES(IN_BYTES)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_data (in_data),
        .pop_n     (pop_n),
        .q_bytes   (q_bytes),
        .q_count   (q_count)
    );
endmodule

// File: rtl/ia_aligner_chk.sv
module ia_aligner_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             out_valid,
    input logic [63:0]      out_insn,
    input logic [1:0]       out_len,
    input logic             out_unsup,
    input logic [CNT_W-1:0] occ
);
    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R1
    short_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 2'd0) |-> (out_insn[47:0] == 48'h0));

    // R2
    plain_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_insn[63:58] != 6'd0) |-> (out_len == 2'd1 && !out_unsup));

    // R6
    unsup_short_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unsup) |-> (out_len == 2'd0));

    // R7
    whole_insn_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(occ) >= 2 * (int'(out_len) + 1)));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0 && !out_valid));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);
endmodule

bind ia_aligner ia_aligner_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .out_valid (out_valid),
    .out_insn  (out_insn),
    .out_len   (out_len),
    .out_unsup (out_unsup),
    .occ       (q_count)
);

// File: tb/ia_aligner_bench.sv
module ia_aligner_bench;
    localparam int IN_BYTES = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0;
    logic        in_ready;
    logic        out_valid;
    logic [63:0] out_insn;
    logic [1:0]  out_len;
    logic        out_unsup;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  stream [64];
    int          sn = 0;
    logic [63:0] cap_insn [64];
    logic [1:0]  cap_len [64];
    logic        cap_unsup [64];
    int          cap_n = 0;

    always #5 clk = ~clk;

    ia_aligner #(.IN_BYTES(IN_BYTES)) u_ia_aligner (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_insn(out_insn),
        .out_len(out_len), .out_unsup(out_unsup)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 64) begin
            cap_insn[cap_n]  = out_insn;
            cap_len[cap_n]   = out_len;
            cap_unsup[cap_n] = out_unsup;
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_bytes(input logic [7:0] b0, input logic [7:0] b1);
        if (b0[7:2] != 6'd0) return 4;
        case ({b0[1:0], b1[7]})
            3'd0, 3'd1: return 2;
            3'd2, 3'd3: return 6;
            3'd4, 3'd5: return 8;
            default:    return 2;
        endcase
    endfunction

    task automatic add(input logic [7:0] b);
        stream[sn] = b;
        sn++;
    endtask

    task automatic push_hw(input logic [15:0] d);
        in_valid = 1'b1;
        in_data  = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_stream(input string req);
        int p;
        int idx;
        int nb;
        logic [63:0] e;
        for (int h = 0; h < sn; h += 2) push_hw({stream[h], stream[h+1]});
        idle(6);
        p = 0;
        idx = 0;
        while (p + 1 < sn) begin
            nb = ref_bytes(stream[p], stream[p+1]);
            e = '0;
            for (int k = 0; k < nb; k++) e[63-8*k -: 8] = stream[p+k];
            check(idx < cap_n && cap_insn[idx] == e, req, cap_insn[idx], e);
            check(idx < cap_n && cap_len[idx] == 2'(nb/2 - 1), req, 64'(cap_len[idx]), 64'(nb/2 - 1));
            check(idx < cap_n && cap_unsup[idx] == (stream[p][7:0] == 8'h03 ? 1'b1 : (stream[p][7:2]==6'd0 && stream[p][1:0]==2'd3)),
                  req, 64'(cap_unsup[idx]), 64'(stream[p][7:2]==6'd0 && stream[p][1:0]==2'd3));
            p += nb;
            idx++;
        end
        check(cap_n == idx, {req, " count"}, 64'(cap_n), 64'(idx));
        sn = 0;
        cap_n = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
        cap_n = 0;
    endtask

    task automatic t_plain32();
        add(8'h7C); add(8'h01); add(8'h02); add(8'h03);
        add(8'h04); add(8'hA5); add(8'h5A); add(8'hFF);
        add(8'hFC); add(8'h00); add(8'h00); add(8'h11);
        run_stream("R2 R1 plain 32-bit");
    endtask

    task automatic t_short16();
        add(8'h00); add(8'h12);
        add(8'h00); add(8'hC4);
        add(8'h00); add(8'h7F);
        run_stream("R3 R1 compressed 16-bit");
    endtask

    task automatic t_long();
        add(8'h01); add(8'h23); add(8'h45); add(8'h67); add(8'h89); add(8'hAB);
        add(8'h01); add(8'h80); add(8'h11); add(8'h22); add(8'h33); add(8'h44);
        add(8'h02); add(8'h00); add(8'h10); add(8'h20); add(8'h30); add(8'h40); add(8'h50); add(8'h60);
        add(8'h02); add(8'hFF); add(8'hEE); add(8'hDD); add(8'hCC); add(8'hBB); add(8'hAA); add(8'h99);
        run_stream("R4 R5 48/64-bit");
    endtask

    task automatic t_mixed();
        add(8'h02); add(8'h80); add(8'h01); add(8'h02); add(8'h03); add(8'h04); add(8'h05); add(8'h06);
        add(8'h00); add(8'h33);
        add(8'h48); add(8'h00); add(8'h00); add(8'h01);
        add(8'h01); add(8'h00); add(8'hDE); add(8'hAD); add(8'hBE); add(8'hEF);
        add(8'h00); add(8'hF0);
        run_stream("R7 mixed order");
    endtask

    task automatic t_unsup();
        add(8'h03); add(8'h00);
        add(8'h03); add(8'hFF);
        add(8'h38); add(8'h60); add(8'h00); add(8'h01);
        run_stream("R6 variable block");
    endtask

    task automatic t_stall();
        push_hw(16'h0200);
        push_hw(16'h1111);
        push_hw(16'h2222);
        idle(4);
        check(cap_n == 0, "R7 partial held", 64'(cap_n), 64'd0);
        check(out_valid == 1'b0, "R7 out_valid low", 64'(out_valid), 64'd0);
        push_hw(16'h3333);
        check(in_ready == 1'b0, "R9 full buffer", 64'(in_ready), 64'd0);
        idle(3);
        check(cap_n == 1 && cap_insn[0] == 64'h0200_1111_2222_3333, "R7 R5 released",
              cap_insn[0], 64'h0200_1111_2222_3333);
        check(cap_len[0] == 2'd3, "R5 len", 64'(cap_len[0]), 64'd3);
        check(in_ready == 1'b1, "R9 drained", 64'(in_ready), 64'd1);
        cap_n = 0;
    endtask

    task automatic t_flush();
        push_hw(16'h0100);
        push_hw(16'hAAAA);
        flush = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 valid during flush", 64'(out_valid), 64'd0);
        @(posedge clk);
        #1;
        flush = 1'b0;
        add(8'h00); add(8'h55);
        add(8'h60); add(8'h00); add(8'h00); add(8'h00);
        run_stream("R8 realign after flush");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        t_reset();
        t_plain32();
        t_short16();
        t_long();
        t_mixed();
        t_unsup();
        t_stall();
        t_flush();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule